// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one unsigned W-bit operand by another over a series of clock cycles. Each step produces one quotient bit, most significant first. A single datapath holds a 2W-bit working register, a latched copy of the divisor and a quotient shift register. A mode input decides where the dividend is placed in the working register:

- In integer mode the dividend goes into the low half, and the result is a whole quotient and remainder.
- In fraction mode the dividend goes into the high half. Both operands are then read as binary fractions, and the quotient is a fraction with its binary point on the left.

A caller presents the operands and pulses `start` while the block is idle. The block raises `busy` and runs W steps. It then raises `done` for one cycle, with `quotient`, `remainder` and `overflow` valid. These outputs hold until the next accepted start. A zero divisor, or a fraction division whose result would not be below one, is flagged at once without running the steps.

Top module: `seq_divider`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done` and `overflow` are 0, and `quotient` and `remainder` are 0.
- R2: In integer mode (`frac_mode`=0) with a nonzero divisor d, the result is `quotient` = floor(D/d) and `remainder` = D mod d. For example, with W=6, 45 divided by 6 gives quotient 7 and remainder 3.
- R3: In fraction mode (`frac_mode`=1) with D < d, the result is `quotient` = floor(D·2^W / d) and `remainder` = D·2^W − quotient·d.
- R4: In fraction mode with d ≠ 0 and D ≥ d, the block sets `overflow`=1 and `quotient`=0, and `remainder` equals D. `done` is high in the cycle right after the accepting edge.
- R5: A zero divisor in either mode sets `overflow`=1 and `quotient`=0. `done` is high right after the accepting edge. `remainder` is 0 in integer mode and D in fraction mode.
- R6: A division without overflow keeps `busy` high from the accepting edge on. `done` is first seen W+1 rising edges after the start was sampled.
- R7: `done` is high for exactly one cycle, and `busy` is high while it is. On the next cycle both are low.
- R8: A `start` seen while `busy` is high is ignored. The operands are captured on the accepting edge, so later changes to the input ports do not alter the running division.
- R9: From `done` until the next accepted start, `quotient`, `remainder` and `overflow` hold their values.
- R10: A division that completes without overflow reports `overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; sampled only while idle |
| frac_mode | input | 1 | 0 = integer division, 1 = fraction division |
| dividend | input | W | Dividend D |
| divisor | input | W | Divisor d |
| busy | output | 1 | Division in progress or completing |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Quotient bits |
| remainder | output | W | Remainder from the high half of the working register |
| overflow | output | 1 | Zero divisor or fraction divide overflow |

## Verification
The assertions assume the caller lets reset settle before requesting work. They also assume that `start` is taken as a request only when the block is idle, so once `busy` rises the latched divisor must not move until completion. The bench keeps within this by driving all inputs on the falling edge. It pulses `start` for a single cycle, and it only issues a new request after observing `done` and one idle cycle. The only exception is the deliberate R8 case, which raises `start` mid-run to show it is ignored. The operand sweep covers every dividend and divisor pair at W=6 in both modes. This includes zero divisors and every fraction pair with D ≥ d, so every overflow path is reached.

// File: rtl/div_pkg.sv
`timescale 1ns/1ps
package div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

  typedef enum logic {
    MODE_INT  = 1'b0,
    MODE_FRAC = 1'b1
  } div_mode_e;

endpackage

// File: rtl/div_ctrl.sv
`timescale 1ns/1ps
module div_ctrl
  import div_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 early_ovf,
  output logic                 load,
  output logic                 step_en,
  output logic                 busy,
  output logic                 done,
  output logic [$clog2(W)-1:0] step_cnt
);

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_state_e state_q;

  assign load    = (state_q == ST_IDLE) && start;
  assign step_en = (state_q == ST_RUN);
  assign busy    = (state_q != ST_IDLE);
  assign done    = (state_q == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      step_cnt <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            step_cnt <= '0;
            state_q  <= early_ovf ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (step_cnt == LAST) begin
            state_q <= ST_FIN;
          end else begin
            step_cnt <= step_cnt + 1'b1;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/div_datapath.sv
`timescale 1ns/1ps
module div_datapath
  import div_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step_en,
  input  logic         frac_mode,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         early_ovf,
  output logic         qbit,
  output logic [W-1:0] dvsr_q,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         overflow
);

  localparam int AW = 2 * W;

  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_next;

  // Overflow seen before any step: zero divisor, or fraction result >= 1.
  function automatic logic precheck(input logic fm, input logic [W-1:0] d_in,
                                    input logic [W-1:0] v);
    return (v == '0) || (fm && (d_in >= v));
  endfunction

  // Initial placement of the dividend within the working register.
  function automatic logic [AW-1:0] place(input logic fm, input logic [W-1:0] d_in);
    return fm ? {d_in, {W{1'b0}}} : {{W{1'b0}}, d_in};
  endfunction

  // One restoring step: shift left, compare W+1 top bits with the divisor.
  function automatic logic [AW:0] restore_step(input logic [AW-1:0] a,
                                               input logic [W-1:0] v);
    logic [W:0] trial;
    logic [W:0] diff;
    trial = a[AW-1:W-1];
    diff  = trial - {1'b0, v};
    if (trial >= {1'b0, v}) begin
      return {1'b1, diff[W-1:0], a[W-2:0], 1'b0};
    end
    return {1'b0, a[AW-2:0], 1'b0};
  endfunction

  assign early_ovf          = precheck(frac_mode, dividend, divisor);
  assign {qbit, acc_next}   = restore_step(acc_q, dvsr_q);
  assign remainder          = acc_q[AW-1:W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      dvsr_q   <= '0;
      quotient <= '0;
      overflow <= 1'b0;
    end else if (load) begin
      acc_q    <= place(frac_mode, dividend);
      dvsr_q   <= divisor;
      quotient <= '0;
      overflow <= early_ovf;
    end else if (step_en) begin
      acc_q    <= acc_next;
      quotient <= {quotient[W-2:0], qbit};
    end
  end

endmodule

// File: rtl/seq_divider.sv
`timescale 1ns/1ps
module seq_divider
  import div_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         frac_mode,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         overflow
);

  localparam int CW = $clog2(W);

  logic          load;
  logic          step_en;
  logic          early_ovf;
  logic          qbit;
  logic [W-1:0]  dvsr_q;
  logic [CW-1:0] step_cnt;

  div_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .early_ovf(early_ovf),
    .load     (load),
    .step_en  (step_en),
    .busy     (busy),
    .done     (done),
    .step_cnt (step_cnt)
  );

  div_datapath #(.W(W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step_en  (step_en),
    .frac_mode(frac_mode),
    .dividend (dividend),
    .divisor  (divisor),
    .early_ovf(early_ovf),
    .qbit     (qbit),
    .dvsr_q   (dvsr_q),
    .quotient (quotient),
    .remainder(remainder),
    .overflow (overflow)
  );

endmodule

// File: rtl/div_checker.sv
`timescale 1ns/1ps
module div_checker #(
  parameter int W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 overflow,
  input logic [W-1:0]         quotient,
  input logic [W-1:0]         remainder,
  input logic [W-1:0]         dvsr_q,
  input logic [$clog2(W)-1:0] step_cnt
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R7
  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R8
  AST_DIVISOR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> $stable(dvsr_q)); // R8
  AST_OVF_NO_QUOT: assert property (@(posedge clk) disable iff (!rst_n) (done && overflow) |-> (quotient == '0)); // R4
  AST_REM_BELOW: assert property (@(posedge clk) disable iff (!rst_n) (done && !overflow) |-> (remainder < dvsr_q)); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) done |=> ($stable(quotient) && $stable(remainder) && $stable(overflow))); // R9
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (int'(step_cnt) < W)); // R6

endmodule

bind seq_divider div_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .overflow (overflow),
  .quotient (quotient),
  .remainder(remainder),
  .dvsr_q   (dvsr_q),
  .step_cnt (step_cnt)
);

// File: tb/tb_seq_divider.sv
`timescale 1ns/1ps
module tb_seq_divider;

  localparam int W = 6;
  localparam int LIM = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         frac_mode = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, overflow;
  logic [W-1:0] quotient, remainder;

  int vectors = 0;
  int errors  = 0;

  always #2.5 clk = ~clk;

  seq_divider #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .frac_mode(frac_mode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic launch(input int d_in, input int v, input bit fm, output int lat,
                        output bit busy_seen);
    @(negedge clk);
    dividend  = W'(d_in);
    divisor   = W'(v);
    frac_mode = fm;
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
    busy_seen = busy;
    lat       = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_and_check(input int d_in, input int v, input bit fm);
    int lat;
    bit bs;
    int q_e, r_e, lat_e;
    bit ovf_e;
    string tag;
    logic [W-1:0] q_seen;
    launch(d_in, v, fm, lat, bs);
    ovf_e = (v == 0) || (fm && d_in >= v);
    if (ovf_e) begin
      q_e   = 0;
      r_e   = fm ? d_in : 0;
      lat_e = 1;
      tag   = (v == 0) ? "R5" : "R4";
    end else if (!fm) begin
      q_e = d_in / v;
      r_e = d_in % v;
      lat_e = W + 1;
      tag = "R2";
    end else begin
      q_e = (d_in * LIM) / v;
      r_e = (d_in * LIM) % v;
      lat_e = W + 1;
      tag = "R3";
    end
    chk(int'(quotient) == q_e, {tag, " quotient"}, int'(quotient), q_e);
    chk(int'(remainder) == r_e, {tag, " remainder"}, int'(remainder), r_e);
    chk(overflow == ovf_e, ovf_e ? {tag, " overflow"} : "R10 overflow", int'(overflow), int'(ovf_e));
    chk(lat == lat_e, ovf_e ? {tag, " latency"} : "R6 latency", lat, lat_e);
    chk(bs == 1'b1, "R6 busy", int'(bs), 1);
    chk(done && busy, "R7 busy with done", int'(busy), 1);
    q_seen = quotient;
    dividend = ~dividend;
    divisor  = ~divisor;
    @(negedge clk);
    chk(!done && !busy, "R7 done single pulse", int'(done), 0);
    chk(quotient == q_seen, "R9 quotient held", int'(quotient), int'(q_seen));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    vectors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int lat;
    bit bs;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !overflow && quotient == 0 && remainder == 0,
        "R1 in reset", int'(quotient), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !overflow && quotient == 0 && remainder == 0,
        "R1 after reset", int'(remainder), 0);

    // R2 worked example
    run_and_check(45, 6, 1'b0);
    chk(quotient == 7, "R2 45/6 quotient", int'(quotient), 7);
    chk(remainder == 3, "R2 45/6 remainder", int'(remainder), 3);

    // R8: start and operand changes during a run are ignored
    @(negedge clk);
    dividend = 6'd45; divisor = 6'd6; frac_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    dividend = 6'd63; divisor = 6'd1; frac_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 3;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(quotient == 7, "R8 quotient unaffected", int'(quotient), 7);
    chk(remainder == 3, "R8 remainder unaffected", int'(remainder), 3);
    chk(lat == W + 1, "R8 no restart", lat, W + 1);
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk(quotient == 7 && remainder == 3 && !overflow, "R9 held while idle",
        int'(quotient), 7);

    // exhaustive sweep, both modes
    for (int fm = 0; fm < 2; fm++) begin
      for (int a = 0; a < LIM; a++) begin
        for (int b = 0; b < LIM; b++) begin
          run_and_check(a, b, fm[0]);
        end
      end
    end

    launch(5, 0, 1'b0, lat, bs);
    chk(overflow && quotient == 0 && remainder == 0, "R5 integer zero divisor",
        int'(remainder), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule